// File: doc/BRIEF.md
# Serial Character Transmitter with Programmable Framing

This block turns parallel characters into an asynchronous serial stream. Characters are written through a simple write strobe and wait in a 16-entry holding queue. A frame engine takes them from the queue one at a time and drives each one onto the serial output line. Bit timing comes from an external clock enable that pulses at sixteen times the bit rate. The frame is built from a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits.

Two status outputs report progress. The first shows whether the holding queue is empty. The second shows whether the whole path is empty, meaning the queue and the frame engine both hold nothing. A gate input pauses the stream at character boundaries. A break input pulls the line low. A clear strobe discards everything still waiting in the queue.

The frame format inputs are captured when a character is taken from the queue. Software-style reconfiguration between characters therefore never disturbs a frame that is already on the line.

Top module: `sertx_core`

## Requirements
- R1: A frame is a start bit at 0, then the data bits with the least significant bit first, then any parity bit, then the stop bits at 1. After the start bit, every bit lasts exactly 16 pulses of `tick`, and the start bit lasts at most 16.
- R2: `word_sel` picks the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected width are not sent.
- R3: With `two_stop` at 0 a frame ends with one stop bit, and with `two_stop` at 1 it ends with two. When another character is waiting, the next start bit follows the last stop bit with no idle gap, so the start edges of consecutive frames are 16 times the frame length in ticks apart.
- R4: When `par_en` is 1, a parity bit follows the data bits. It is set by `par_mode` as follows:
  - 00: the parity bit makes the number of ones across data and parity odd.
  - 01: the parity bit makes that number even.
  - 10: the parity bit is always 1.
  - 11: the parity bit is always 0.

  When `par_en` is 0, no parity bit is sent.
- R5: One clock after `brk` is sampled high, `txd` is 0. It stays 0 for as long as `brk` stays high, whether the line is idle or a frame is being shifted.
- R6: `hold_empty` is 1 exactly when the holding queue is empty. It drops in the cycle after a write into an empty queue, and it returns to 1 as soon as the frame engine takes the last character.
- R7: `tx_empty` is 1 only when the holding queue is empty and no frame is in progress. It stays 0 while the last character is still on the line.
- R8: If `tx_en` drops while a frame is on the line, that frame completes. After that, no new frame starts until `tx_en` is 1 again, and the waiting characters stay queued.
- R9: The holding queue keeps up to 16 characters in write order. A write while the queue is full is discarded.
- R10: A pulse on `fifo_clr` empties the holding queue and resets its pointers. Characters written later are sent normally. A write in the same cycle as a clear is discarded.
- R11: After reset, `txd` is 1 and both `hold_empty` and `tx_empty` are 1. The idle line level is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding queue |
| wr_data | input | DATA_W | Character to queue |
| fifo_clr | input | 1 | Empties the holding queue |
| tx_en | input | 1 | Allows new frames to start |
| word_sel | input | 2 | Data bit count select (00=5 to 11=8) |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | 1 adds a parity bit |
| par_mode | input | 2 | Parity rule: odd, even, constant 1, constant 0 |
| brk | input | 1 | Forces the line low |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding queue empty |
| tx_empty | output | 1 | Queue and frame engine both empty |

## Verification
Several properties are checked by assertions on every cycle:
- the break override of the line;
- the line resting high whenever the path was empty;
- a write into an empty queue always clearing `hold_empty`;
- `tx_empty` never being set while `hold_empty` is clear;
- the frame engine never leaving idle while `tx_en` is low.

Other behaviours can only be shown by the bench scenarios, which capture whole frames at bit midpoints:
- the bit order and the length of each bit;
- the word length;
- the four parity rules;
- the stop count and the spacing between back-to-back frames;
- the 16-entry depth with dropped overflow writes;
- the queue clear;
- a pause that lets the current frame finish.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [1:0] wsel;
        logic       two_stop;
        logic       par_en;
        par_mode_e  pmode;
    } frame_cfg_t;

    // Parity bit to send, given whether the data already holds an odd count of ones
    function automatic logic mode_parity(logic ones_odd, par_mode_e m);
        case (m)
            PAR_ODD:  return ~ones_odd;
            PAR_EVEN: return ones_odd;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push & ~full & ~clr;
    assign pop_ok  = pop & ~empty & ~clr;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          tx_en,
    input  logic          avail,
    input  logic [DW-1:0] din,
    input  frame_cfg_t    cfg,
    output logic          take,
    output logic          line,
    output logic          busy
);
    localparam int SW = $clog2(OSR);
    localparam int IW = $clog2(DW);

    phase_e        phase;
    logic [SW-1:0] sub;
    logic [IW-1:0] idx, last_idx;
    logic [DW-1:0] shreg, mask;
    logic          par_q, par_on, two_q, stop_idx;
    logic          bit_end, frame_end, can_load;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i <= DW - 4 + int'(cfg.wsel));
        end
    end

    assign bit_end   = tick && (phase != PH_IDLE) && (sub == SW'(OSR - 1));
    assign frame_end = bit_end && (phase == PH_STOP) && (stop_idx == two_q);
    assign can_load  = tx_en & avail;
    assign take      = can_load && ((phase == PH_IDLE) || frame_end);
    assign busy      = (phase != PH_IDLE);

    always_comb begin
        case (phase)
            PH_START: line = 1'b0;
            PH_DATA:  line = shreg[0];
            PH_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            sub      <= '0;
            idx      <= '0;
            last_idx <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            par_on   <= 1'b0;
            two_q    <= 1'b0;
            stop_idx <= 1'b0;
        end else if (take) begin
            phase    <= PH_START;
            sub      <= '0;
            idx      <= '0;
            last_idx <= IW'(DW - 4 + int'(cfg.wsel));
            shreg    <= din & mask;
            par_q    <= mode_parity(^(din & mask), cfg.pmode);
            par_on   <= cfg.par_en;
            two_q    <= cfg.two_stop;
            stop_idx <= 1'b0;
        end else if (tick && phase != PH_IDLE) begin
            sub <= bit_end ? '0 : sub + SW'(1);
            if (bit_end) begin
                case (phase)
                    PH_START: begin
                        phase <= PH_DATA;
                        idx   <= '0;
                    end
                    PH_DATA: begin
                        if (idx == last_idx) begin
                            phase    <= par_on ? PH_PAR : PH_STOP;
                            stop_idx <= 1'b0;
                        end else begin
                            idx   <= idx + IW'(1);
                            shreg <= shreg >> 1;
                        end
                    end
                    PH_PAR: begin
                        phase    <= PH_STOP;
                        stop_idx <= 1'b0;
                    end
                    PH_STOP: begin
                        if (stop_idx == two_q) phase <= PH_IDLE;
                        else                   stop_idx <= 1'b1;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int OSR        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fifo_clr,
    input  logic              tx_en,
    input  logic [1:0]        word_sel,
    input  logic              two_stop,
    input  logic              par_en,
    input  logic [1:0]        par_mode,
    input  logic              brk,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);
    logic [DATA_W-1:0] q_head;
    logic              q_empty, q_full, q_pop;
    logic              shf_line, shf_busy;
    logic              txd_q;
    frame_cfg_t        cfg;

    assign cfg.wsel     = word_sel;
    assign cfg.two_stop = two_stop;
    assign cfg.par_en   = par_en;
    assign cfg.pmode    = par_mode_e'(par_mode);

    sertx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    sertx_shifter #(.DW(DATA_W), .OSR(OSR)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .tx_en (tx_en),
        .avail (~q_empty & ~fifo_clr),
        .din   (q_head),
        .cfg   (cfg),
        .take  (q_pop),
        .line  (shf_line),
        .busy  (shf_busy)
    );

    // Registered line output with break override
    always_ff @(posedge clk) begin
        if (rst) txd_q <= 1'b1;
        else     txd_q <= shf_line & ~brk;
    end

    logic unused_full;
    assign unused_full = q_full;

    assign txd        = txd_q;
    assign hold_empty = q_empty;
    assign tx_empty   = q_empty & ~shf_busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst,
    input logic brk,
    input logic txd,
    input logic tx_en,
    input logic busy,
    input logic wr_en,
    input logic fifo_clr,
    input logic hold_empty,
    input logic tx_empty
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        armed && $past(brk) |-> !txd);  // R5

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        armed && $past(tx_empty) && !$past(brk) |-> txd);  // R11

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        armed && $past(wr_en) && !$past(fifo_clr) && $past(hold_empty) |-> !hold_empty);  // R6

    AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);  // R7

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tx_en && !busy |=> !busy);  // R8

endmodule

bind sertx_core sertx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .brk        (brk),
    .txd        (txd),
    .tx_en      (tx_en),
    .busy       (shf_busy),
    .wr_en      (wr_en),
    .fifo_clr   (fifo_clr),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_clr = 1'b0;
    logic       tx_en = 1'b1;
    logic [1:0] word_sel = 2'b11;
    logic       two_stop = 1'b0;
    logic       par_en = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       brk = 1'b0;
    logic       txd, hold_empty, tx_empty;

    int  n_checks = 0;
    int  n_fail = 0;
    int  tdiv = 1;
    int  tcnt = 0;
    int  cyc = 0;
    int  last_fall = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sertx_core dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_clr(fifo_clr), .tx_en(tx_en), .word_sel(word_sel), .two_stop(two_stop),
        .par_en(par_en), .par_mode(par_mode), .brk(brk),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (tcnt >= tdiv - 1) begin tick = 1'b1; tcnt = 0; end
            else begin tick = 1'b0; tcnt = tcnt + 1; end
        end
    end

    task automatic check_val(string req, string what, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int frame_len(logic [1:0] ws, logic pe, logic two);
        return 1 + 5 + int'(ws) + int'(pe) + 1 + int'(two);
    endfunction

    function automatic logic [11:0] model_frame(logic [7:0] d, logic [1:0] ws,
                                                logic pe, logic [1:0] pm, logic two);
        logic [11:0] f = '0;
        int nb = 5 + int'(ws);
        int ones = 0;
        int pos;
        f[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            f[1+i] = d[i];
            if (d[i]) ones++;
        end
        pos = 1 + nb;
        if (pe) begin
            case (pm)
                2'b00: f[pos] = (ones % 2 == 0);
                2'b01: f[pos] = (ones % 2 == 1);
                2'b10: f[pos] = 1'b1;
                default: f[pos] = 1'b0;
            endcase
            pos++;
        end
        f[pos] = 1'b1;
        if (two) f[pos+1] = 1'b1;
        return f;
    endfunction

    task automatic write_char(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic capture(input int n, output logic [11:0] got);
        int waited = 0;
        got = '0;
        while (txd !== 1'b0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        last_fall = cyc;
        if (waited >= 4000) begin
            check_val("R1", "start bit timeout", 1, 0);
            return;
        end
        repeat (8 * tdiv) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (16 * tdiv) @(negedge clk);
            got[i] = txd;
        end
    endtask

    task automatic send_and_check(string req, logic [7:0] d);
        logic [11:0] got;
        int n = frame_len(word_sel, par_en, two_stop);
        write_char(d);
        capture(n, got);
        check_val(req, "frame bits", int'(got),
                  int'(model_frame(d, word_sel, par_en, par_mode, two_stop)));
    endtask

    task automatic wait_quiet(int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
    endtask

    task automatic t_reset;
        check_val("R11", "txd after reset", int'(txd), 1);
        check_val("R11", "hold_empty after reset", int'(hold_empty), 1);
        check_val("R11", "tx_empty after reset", int'(tx_empty), 1);
    endtask

    task automatic t_formats;
        word_sel = 2'b11; send_and_check("R1", 8'hA5);
        word_sel = 2'b00; send_and_check("R2", 8'hF6);
        word_sel = 2'b01; send_and_check("R2", 8'h9B);
        word_sel = 2'b10; send_and_check("R2", 8'hC9);
        word_sel = 2'b11; two_stop = 1'b1; send_and_check("R3", 8'h3C);
        repeat (40) @(negedge clk);
        two_stop = 1'b0;
    endtask

    task automatic t_spacing(logic two);
        logic [11:0] got;
        int f1;
        int n;
        two_stop = two; word_sel = 2'b11;
        n = frame_len(word_sel, par_en, two_stop);
        write_char(8'h81);
        write_char(8'h7E);
        capture(n, got);
        f1 = last_fall;
        check_val("R3", "first chained frame", int'(got), int'(model_frame(8'h81, 2'b11, 1'b0, 2'b00, two)));
        capture(n, got);
        check_val("R3", "second chained frame", int'(got), int'(model_frame(8'h7E, 2'b11, 1'b0, 2'b00, two)));
        check_val("R3", "start-to-start cycles", last_fall - f1, 16 * n);
        repeat (40) @(negedge clk);
        two_stop = 1'b0;
    endtask

    task automatic t_parity;
        par_en = 1'b1; word_sel = 2'b11;
        for (int m = 0; m < 4; m++) begin
            par_mode = 2'(m);
            send_and_check("R4", 8'h0B);
        end
        word_sel = 2'b00; par_mode = 2'b00;
        send_and_check("R4", 8'hE3);
        par_mode = 2'b01;
        send_and_check("R4", 8'hE3);
        repeat (40) @(negedge clk);
        par_en = 1'b0; par_mode = 2'b00; word_sel = 2'b11;
    endtask

    task automatic t_pacing;
        tdiv = 3;
        send_and_check("R1", 8'h5A);
        repeat (100) @(negedge clk);
        tdiv = 1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_status;
        logic [11:0] got;
        write_char(8'hC3);
        check_val("R6", "hold_empty after write", int'(hold_empty), 0);
        check_val("R7", "tx_empty after write", int'(tx_empty), 0);
        @(negedge clk);
        check_val("R6", "hold_empty once taken", int'(hold_empty), 1);
        check_val("R7", "tx_empty while shifting", int'(tx_empty), 0);
        capture(10, got);
        check_val("R1", "status frame", int'(got), int'(model_frame(8'hC3, 2'b11, 1'b0, 2'b00, 1'b0)));
        check_val("R7", "tx_empty in last stop bit", int'(tx_empty), 0);
        repeat (16) @(negedge clk);
        check_val("R7", "tx_empty after frame", int'(tx_empty), 1);
    endtask

    task automatic t_enable;
        logic [11:0] got;
        int lows;
        write_char(8'h96);
        write_char(8'h69);
        tx_en = 1'b0;
        capture(10, got);
        check_val("R8", "frame in progress completes", int'(got), int'(model_frame(8'h96, 2'b11, 1'b0, 2'b00, 1'b0)));
        wait_quiet(600, lows);
        check_val("R8", "line lows while disabled", lows, 0);
        check_val("R8", "queued char kept", int'(hold_empty), 0);
        tx_en = 1'b1;
        capture(10, got);
        check_val("R8", "frame after re-enable", int'(got), int'(model_frame(8'h69, 2'b11, 1'b0, 2'b00, 1'b0)));
        repeat (40) @(negedge clk);
    endtask

    task automatic t_depth;
        logic [11:0] got;
        int bad = 0;
        int lows;
        tx_en = 1'b0;
        for (int i = 0; i < 17; i++) write_char(8'h30 + 8'(i));
        check_val("R9", "hold_empty with full queue", int'(hold_empty), 0);
        tx_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            capture(10, got);
            if (got !== model_frame(8'h30 + 8'(i), 2'b11, 1'b0, 2'b00, 1'b0)) bad++;
        end
        check_val("R9", "mismatched frames of 16", bad, 0);
        wait_quiet(400, lows);
        check_val("R9", "overflow write dropped", lows, 0);
        check_val("R9", "tx_empty after drain", int'(tx_empty), 1);
    endtask

    task automatic t_clear;
        int lows;
        tx_en = 1'b0;
        write_char(8'h11);
        write_char(8'h22);
        write_char(8'h33);
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
        check_val("R10", "hold_empty after clear", int'(hold_empty), 1);
        check_val("R10", "tx_empty after clear", int'(tx_empty), 1);
        tx_en = 1'b1;
        wait_quiet(400, lows);
        check_val("R10", "nothing sent after clear", lows, 0);
        send_and_check("R10", 8'h4D);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_break;
        int highs = 0;
        logic [11:0] got;
        @(negedge clk); brk = 1'b1;
        @(negedge clk);
        check_val("R5", "txd one clock after break", int'(txd), 0);
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (txd !== 1'b0) highs++; end
        brk = 1'b0;
        @(negedge clk);
        check_val("R5", "idle line after break", int'(txd), 1);
        write_char(8'h55);
        capture(1, got);
        repeat (20) @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (txd !== 1'b0) highs++; end
        check_val("R5", "highs while break held", highs, 0);
        brk = 1'b0;
        repeat (200) @(negedge clk);
        check_val("R5", "line high after break and frame", int'(txd), 1);
        check_val("R7", "tx_empty after broken frame", int'(tx_empty), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_formats();
        t_spacing(1'b0);
        t_spacing(1'b1);
        t_parity();
        t_pacing();
        t_status();
        t_enable();
        t_depth();
        t_clear();
        t_break();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule